// File: doc/BRIEF.md
# LCD Controller Interrupt Status and Enable Unit

This unit gathers single-cycle event pulses from a display controller's raster timing and DMA engines. Each pulse is latched into a raw status register. An enable mask selects which pending events may raise the single interrupt line. Software changes the mask only through two dedicated write ports: one sets bits and one clears them. Software acknowledges events by writing ones to the masked status address.

To finish a service routine, software writes the end-of-interrupt address. The interrupt line then drops for at least one cycle. It rises again if any enabled event is still pending, so an edge-sensitive interrupt controller sees a fresh edge for work that is left over. Register access is a plain address/write-strobe port with a combinational read path.

Top module: `lcd_irq_ctrl`

## Requirements
- R1: After reset the raw status, the enable mask and the interrupt output are all zero.
- R2: A pulse on an implemented event input sets the matching raw status bit, whether or not that event is enabled. Raw status is read at offset 0x58. Implemented event bits are 9 and 8 (end of frame, buffers 1 and 0), 6 (palette loaded), 5 (FIFO underflow), 3 (AC-bias count done), 2 (sync lost), 1 (raster done) and 0 (frame done).
- R3: Bits 7 and 4, and all bits above 9, read as zero in raw status, masked status and the enable mask, whatever is written or pulsed.
- R4: Writing offset 0x60 sets every enable bit written as 1 and leaves the others unchanged. The enable mask reads back at both 0x60 and 0x64.
- R5: Writing offset 0x64 clears every enable bit written as 1 and leaves the others unchanged.
- R6: Masked status, read at offset 0x5C, equals raw status AND the enable mask.
- R7: Writing offset 0x5C clears each raw status bit written as 1, including bits whose enable is off. Bits written as 0 are unchanged.
- R8: An event pulse in the same cycle as a clear of that bit leaves the bit set.
- R9: The interrupt output is registered. Outside an end-of-interrupt cycle, it is high exactly when masked status is nonzero.
- R10: A write to offset 0x68, with any data, forces the interrupt output low for the next cycle. In the cycle after that, the output is high again if masked status is still nonzero.
- R11: Writes to 0x58 change nothing. Reads of 0x68 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| evt_pulse | input | EVT_W | One-cycle event pulses, one bit per event |
| irq_out | output | 1 | Interrupt request to the system |

## Verification
The bench builds the unit with its default parameters: an 8-bit offset, a 32-bit data word and a 10-bit event field whose implemented-bit mask leaves bits 7 and 4 empty. This puts the reserved holes inside the event field and the ignored upper data bits within reach of all-ones writes and pulses. The same build also reaches the same-cycle pulse-and-clear race, the clearing of a disabled pending bit, and the one-cycle drop of the interrupt line around an end-of-interrupt write.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;

    // One strobe per write-sensitive register offset
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic st_clr;
        logic eoi;
    } wr_strobe_t;

    // Source selected for the read data path
    typedef enum logic [1:0] {
        RD_NONE,
        RD_RAW,
        RD_MASKED,
        RD_ENABLE
    } rd_sel_t;

endpackage

// File: rtl/lcd_irq_decode.sv
module lcd_irq_decode
    import lcd_irq_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] OFS_RAW = 'h58,
    parameter logic [ADDR_W-1:0] OFS_MSK = 'h5C,
    parameter logic [ADDR_W-1:0] OFS_SET = 'h60,
    parameter logic [ADDR_W-1:0] OFS_CLR = 'h64,
    parameter logic [ADDR_W-1:0] OFS_EOI = 'h68
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output wr_strobe_t        stb_o,
    output rd_sel_t           sel_o
);

    always_comb begin
        stb_o = '0;
        sel_o = RD_NONE;
        if (addr_i == OFS_RAW) begin
            sel_o = RD_RAW;
        end else if (addr_i == OFS_MSK) begin
            sel_o = RD_MASKED;
        end else if (addr_i == OFS_SET || addr_i == OFS_CLR) begin
            sel_o = RD_ENABLE;
        end
        if (wr_i) begin
            stb_o.en_set = (addr_i == OFS_SET);
            stb_o.en_clr = (addr_i == OFS_CLR);
            stb_o.st_clr = (addr_i == OFS_MSK);
            stb_o.eoi    = (addr_i == OFS_EOI);
        end
    end

endmodule

// File: rtl/lcd_irq_regs.sv
module lcd_irq_regs
    import lcd_irq_pkg::*;
#(
    parameter int               EVT_W    = 10,
    parameter logic [EVT_W-1:0] EVT_IMPL = 10'b11_0110_1111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strobe_t       stb_i,
    input  logic [EVT_W-1:0] wbits_i,
    input  logic [EVT_W-1:0] evt_i,
    output logic [EVT_W-1:0] raw_o,
    output logic [EVT_W-1:0] en_o,
    output logic             pend_next_o
);

    typedef struct packed {
        logic [EVT_W-1:0] raw;
        logic [EVT_W-1:0] en;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stb_i.en_set) begin
            s_d.en = s_q.en | (wbits_i & EVT_IMPL);
        end
        if (stb_i.en_clr) begin
            s_d.en = s_q.en & ~wbits_i;
        end
        if (stb_i.st_clr) begin
            s_d.raw = s_q.raw & ~wbits_i;
        end
        // a new pulse wins over a clear in the same cycle
        s_d.raw = s_d.raw | (evt_i & EVT_IMPL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raw_o       = s_q.raw;
    assign en_o        = s_q.en;
    assign pend_next_o = |(s_d.raw & s_d.en);

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i & EVT_IMPL) != '0 |=>
        (s_q.raw & $past(evt_i & EVT_IMPL)) == $past(evt_i & EVT_IMPL)); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.raw | s_q.en) & ~EVT_IMPL) == '0); // R3

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i.en_set |=>
        (s_q.en & $past(wbits_i & EVT_IMPL)) == $past(wbits_i & EVT_IMPL)); // R4

    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i.en_clr |=> (s_q.en & $past(wbits_i)) == '0); // R5

    AST_RAW_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i.st_clr |=> (s_q.raw & $past(s_q.raw)) == $past(s_q.raw)); // R7

endmodule

// File: rtl/lcd_irq_line.sv
module lcd_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic eoi_i,
    input  logic pend_next_i,
    output logic irq_o
);

    typedef struct packed {
        logic irq;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // an end-of-interrupt write holds the line low for one cycle
        s_d.irq = pend_next_i & ~eoi_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;

    AST_EOI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !s_q.irq); // R10

endmodule

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
    import lcd_irq_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                EVT_W    = 10,
    parameter logic [EVT_W-1:0]  EVT_IMPL = 10'b11_0110_1111,
    parameter logic [ADDR_W-1:0] OFS_RAW  = 'h58,
    parameter logic [ADDR_W-1:0] OFS_MSK  = 'h5C,
    parameter logic [ADDR_W-1:0] OFS_SET  = 'h60,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h64,
    parameter logic [ADDR_W-1:0] OFS_EOI  = 'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0]  evt_pulse,
    output logic              irq_out
);

    wr_strobe_t       stb;
    rd_sel_t          sel;
    logic [EVT_W-1:0] raw_q;
    logic [EVT_W-1:0] en_q;
    logic             pend_next;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:EVT_W];

    lcd_irq_decode #(
        .ADDR_W  (ADDR_W),
        .OFS_RAW (OFS_RAW),
        .OFS_MSK (OFS_MSK),
        .OFS_SET (OFS_SET),
        .OFS_CLR (OFS_CLR),
        .OFS_EOI (OFS_EOI)
    ) u_decode (
        .addr_i (reg_addr),
        .wr_i   (reg_wr),
        .stb_o  (stb),
        .sel_o  (sel)
    );

    lcd_irq_regs #(
        .EVT_W    (EVT_W),
        .EVT_IMPL (EVT_IMPL)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (stb),
        .wbits_i     (reg_wdata[EVT_W-1:0]),
        .evt_i       (evt_pulse),
        .raw_o       (raw_q),
        .en_o        (en_q),
        .pend_next_o (pend_next)
    );

    lcd_irq_line u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoi_i       (stb.eoi),
        .pend_next_i (pend_next),
        .irq_o       (irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            RD_RAW:    reg_rdata[EVT_W-1:0] = raw_q;
            RD_MASKED: reg_rdata[EVT_W-1:0] = raw_q & en_q;
            RD_ENABLE: reg_rdata[EVT_W-1:0] = en_q;
            default:   reg_rdata = '0;
        endcase
    end

    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (raw_q & en_q) != '0); // R9

    AST_RAW_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_RAW && evt_pulse == '0) |=> $stable(raw_q)); // R11

endmodule

// File: tb/tb_lcd_irq_ctrl.sv
module tb_lcd_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_RAW = 8'h58;
    localparam logic [7:0] A_MSK = 8'h5C;
    localparam logic [7:0] A_SET = 8'h60;
    localparam logic [7:0] A_CLR = 8'h64;
    localparam logic [7:0] A_EOI = 8'h68;

    // fields: enable-set, enable-clear, event pulse, status clear, expected raw, expected enable
    localparam int NVEC = 6;
    localparam logic [59:0] VEC [NVEC] = '{
        {10'h003, 10'h000, 10'h001, 10'h000, 10'h001, 10'h003},
        {10'h300, 10'h000, 10'h220, 10'h000, 10'h221, 10'h303},
        {10'h000, 10'h001, 10'h0D0, 10'h000, 10'h261, 10'h302},
        {10'h0F0, 10'h000, 10'h000, 10'h021, 10'h240, 10'h362},
        {10'h000, 10'h3FF, 10'h00C, 10'h000, 10'h24C, 10'h000},
        {10'h008, 10'h000, 10'h000, 10'h3FF, 10'h000, 10'h008}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  evt_pulse = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    lcd_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_RAW, d); chk("R1 raw", d, 0);
        rd(A_SET, d); chk("R1 enable", d, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] vset, vclr, vevt, vst, xraw, xen;
            {vset, vclr, vevt, vst, xraw, xen} = VEC[i];
            if (vset != 0) wr(A_SET, {22'b0, vset});
            if (vclr != 0) wr(A_CLR, {22'b0, vclr});
            if (vevt != 0) pulse(vevt);
            if (vst  != 0) wr(A_MSK, {22'b0, vst});
            chk("R9 irq level", {31'b0, irq_out}, {31'b0, |(xraw & xen)});
            rd(A_RAW, d); chk("R2 R3 R7 raw", d, {22'b0, xraw});
            rd(A_MSK, d); chk("R6 masked", d, {22'b0, xraw & xen});
            rd(A_SET, d); chk("R4 enable at set", d, {22'b0, xen});
            rd(A_CLR, d); chk("R5 enable at clear", d, {22'b0, xen});
        end

        // R8 pulse and clear of the same bit in one cycle
        wr(A_SET, 32'h002);
        pulse(10'h002);
        @(negedge clk);
        evt_pulse = 10'h002;
        reg_addr  = A_MSK;
        reg_wdata = 32'h002;
        reg_wr    = 1'b1;
        @(negedge clk);
        evt_pulse = '0;
        reg_wr    = 1'b0;
        rd(A_RAW, d); chk("R8 raw kept", d, 32'h002);
        chk("R9 irq pending", {31'b0, irq_out}, 1);

        // R10 end of interrupt with work left
        wr(A_EOI, 32'hDEAD_BEEF);
        chk("R10 irq drop", {31'b0, irq_out}, 0);
        @(negedge clk);
        chk("R10 irq reassert", {31'b0, irq_out}, 1);

        // R10 end of interrupt with nothing left
        wr(A_MSK, 32'h002);
        chk("R9 irq clear", {31'b0, irq_out}, 0);
        wr(A_EOI, 32'h0);
        @(negedge clk);
        chk("R10 irq stays low", {31'b0, irq_out}, 0);

        // R11 read-only raw and unmapped offsets
        wr(A_RAW, 32'hFFFF_FFFF);
        rd(A_RAW, d); chk("R11 raw write ignored", d, 0);
        rd(8'h00, d); chk("R11 unmapped read", d, 0);
        rd(A_EOI, d); chk("R11 eoi read", d, 0);

        // R3 reserved and upper bits, R5 zero-bit clear
        wr(A_SET, 32'hFFFF_FFFF);
        rd(A_SET, d); chk("R3 enable reserved", d, 32'h36F);
        wr(A_CLR, 32'hFFFF_FC00);
        rd(A_CLR, d); chk("R5 no-op clear", d, 32'h36F);
        pulse(10'h3FF);
        rd(A_RAW, d); chk("R3 raw reserved", d, 32'h36F);

        // R7 clear a disabled pending bit
        wr(A_CLR, 32'h008);
        rd(A_MSK, d); chk("R6 masked disabled", d, 32'h367);
        wr(A_MSK, 32'h008);
        rd(A_RAW, d); chk("R7 disabled clear", d, 32'h367);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule